// File: doc/BRIEF.md
# Cascaded Fall-Through FIFO Chain

This block is a deep first-in first-out buffer made from a row of identical stages. Each stage holds a small circular store and one output register. Every stage works in first-word-fall-through fashion: the oldest stored word is moved into the output register without any read request. A stage signals that it holds a valid output word by pulling its active-low output-ready flag low. It signals that it has room for another word by pulling its active-low input-ready flag low.

Stages are joined directly, with no logic between them. The data output of one stage is the data input of the next. A word moves from stage k to stage k+1 in any cycle where stage k shows a valid output and stage k+1 shows room. Words therefore drift toward the tail on their own, and free slots drift toward the head.

Each stage's read side learns of new writes two cycles late, and its write side learns of freed slots two cycles late. This gives fixed, countable latencies. The first word into an empty chain takes a known time to reach the tail. The first slot freed in a full chain takes a known time to reach the head. Once the chain is primed, words stream through at one per cycle. All stages share one clock. Reset is synchronous and active high.

Top module: `fifo_chain`

## Requirements
- R1: While `rst` is high at a rising edge, both `in_rdy_n` and `out_rdy_n` read high after that edge. After reset the chain is empty: `out_rdy_n` stays high until a word is written, and `in_rdy_n` is low.
- R2: The chain holds exactly STAGES*(2^ADDR_W+1) words. With no reads, writes are accepted until that count is reached, and then `in_rdy_n` stays high.
- R3: A word accepted at rising edge E into an empty chain makes `out_rdy_n` first low after edge E+4*(STAGES-1)+3, with that word on `dout`. No read request is needed.
- R4: In a full, settled chain, a tail read at edge E makes `in_rdy_n` first low after edge E+3*(STAGES-1)+2. It stays high before that.
- R5: With `rd_en` held high and a write offered every cycle into an empty chain (ADDR_W of at least 3), every write is accepted. The tail then delivers one word per cycle, with no gap after the first.
- R6: A write is accepted at an edge only when `wr_en` is high and `in_rdy_n` is low. A write offered while `in_rdy_n` is high stores nothing, and no stored word is lost.
- R7: Words leave `dout` in exactly the order they were accepted at the head, each exactly once, under any pattern of `wr_en` and `rd_en`.
- R8: A read is taken at an edge only when `rd_en` is high and `out_rdy_n` is low. Asserting `rd_en` while `out_rdy_n` is high removes nothing: a word written later still arrives and is delivered.
- R9: While `out_rdy_n` is low and `rd_en` is low at an edge, `out_rdy_n` stays low and `dout` keeps its value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Offer `din` to the head stage |
| din | input | WIDTH | Data written at the head |
| in_rdy_n | output | 1 | Low when the head stage can take a word |
| rd_en | input | 1 | Take the word shown on `dout` |
| dout | output | WIDTH | Oldest word, valid while `out_rdy_n` is low |
| out_rdy_n | output | 1 | Low when a valid word is on `dout` |

## Verification
The occupancy count in the checker assumes that a transfer happens only when an enable coincides with the matching low ready flag. The stimulus therefore drives `wr_en`, `rd_en` and `din` only on falling edges, so that they are settled before the rising edge at which the ready flags are judged. The hold property on `dout` assumes the environment may drop `rd_en` at any time. The random phase does exactly that, with independent enables. The latency checks start from states the bench builds on purpose: the chain is fully drained before a ripple-down measurement, and given a long settle time after filling before a bubble-up measurement.

// File: rtl/fifo_chain.sv
module fifo_chain #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy_n,
  input  logic             rd_en,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy_n
);
  localparam int SLOTS = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [STAGES-1:0] wr, rd, vld, full;
  logic [WIDTH-1:0]  qd [STAGES];

  assign in_rdy_n  = rst | full[0];
  assign out_rdy_n = ~vld[STAGES-1];
  assign dout      = qd[STAGES-1];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [WIDTH-1:0] mem [SLOTS];
    logic [WIDTH-1:0] d_in, q;
    logic [PW-1:0]    wp, wp1, wp2, rp, rp1, rp2;
    logic             v, load;

    if (k == 0) begin : g_head
      assign d_in  = din;
      assign wr[k] = wr_en & ~in_rdy_n;
    end else begin : g_link
      assign d_in  = qd[k-1];
      assign wr[k] = vld[k-1] & ~full[k];
    end

    if (k == STAGES-1) begin : g_tail
      assign rd[k] = rd_en & v;
    end else begin : g_mid
      assign rd[k] = wr[k+1];
    end

    // write side counts freed slots two cycles late; read side sees writes two cycles late
    assign full[k] = (wp - rp2) == PW'(SLOTS);
    assign load    = (rp != wp2) & (~v | rd[k]);
    assign vld[k]  = v;
    assign qd[k]   = q;

    always_ff @(posedge clk) begin
      if (wr[k]) mem[wp[ADDR_W-1:0]] <= d_in;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp  <= '0;
        wp1 <= '0;
        wp2 <= '0;
        rp  <= '0;
        rp1 <= '0;
        rp2 <= '0;
        v   <= 1'b0;
        q   <= '0;
      end else begin
        wp1 <= wp;
        wp2 <= wp1;
        rp1 <= rp;
        rp2 <= rp1;
        if (wr[k]) wp <= wp + PW'(1);
        if (load) begin
          q  <= mem[rp[ADDR_W-1:0]];
          rp <= rp + PW'(1);
          v  <= 1'b1;
        end else if (rd[k]) begin
          v  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3,
  parameter int STAGES = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             in_rdy_n,
  input logic             rd_en,
  input logic             out_rdy_n,
  input logic [WIDTH-1:0] dout
);
  localparam int CAP = STAGES * ((1 << ADDR_W) + 1);
  localparam int CW  = $clog2(CAP + 1) + 1;

  logic [CW-1:0] occ;
  logic in_acc, out_acc;

  assign in_acc  = wr_en & ~in_rdy_n;
  assign out_acc = rd_en & ~out_rdy_n;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + CW'(in_acc) - CW'(out_acc);
  end

  // R1
  reset_flags_chk: assert property (@(posedge clk) rst |=> out_rdy_n);

  // R9
  hold_dout_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_rdy_n && !rd_en) |=> (!out_rdy_n && $stable(dout)));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(CAP));

  // R6
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(CAP)) |-> in_rdy_n);

  // R3
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> out_rdy_n);
endmodule

bind fifo_chain fifo_chain_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .in_rdy_n(in_rdy_n),
  .rd_en(rd_en), .out_rdy_n(out_rdy_n), .dout(dout)
);

// File: tb/sim_fifo_chain.sv
module sim_fifo_chain;
  localparam int CLK_P  = 10;
  localparam int W      = 8;
  localparam int AW     = 3;
  localparam int N      = 3;
  localparam int CAP    = N * ((1 << AW) + 1);
  localparam int LAT_DN = 4 * (N - 1) + 3;
  localparam int LAT_UP = 3 * (N - 1) + 2;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] din = '0;
  logic in_rdy_n, out_rdy_n;
  logic [W-1:0] dout;

  fifo_chain #(.WIDTH(W), .ADDR_W(AW), .STAGES(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .in_rdy_n(in_rdy_n),
    .rd_en(rd_en), .dout(dout), .out_rdy_n(out_rdy_n)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] exp_q[$];
  bit trk = 0;
  int npop = 0, first_pop = 0, last_pop = 0;
  bit hold_prev = 0;
  logic [W-1:0] prev_d = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: values read here are those before the edge
  always @(posedge clk) begin
    if (!rst && hold_prev) check(dout == prev_d && !out_rdy_n, "R9", dout, prev_d);
    hold_prev = !rst && !out_rdy_n && !rd_en;
    prev_d    = dout;
    if (!rst && rd_en && !out_rdy_n) begin
      if (exp_q.size() == 0) check(1'b0, "R7", dout, -1);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(dout == e, "R7", dout, e);
      end
      if (trk) begin
        if (npop == 0) first_pop = cyc + 1;
        last_pop = cyc + 1;
        npop++;
      end
    end
  end

  task automatic drive(input bit we, input logic [W-1:0] d, input bit re, output bit acc);
    @(negedge clk);
    wr_en = we; din = d; rd_en = re;
    acc = we && !in_rdy_n && !rst;
    if (acc) exp_q.push_back(d);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, a);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit a;
    int e, seen, acc_n;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(in_rdy_n && out_rdy_n, "R1", {in_rdy_n, out_rdy_n}, 3);
    rst = 1'b0;
    idle(4);
    check(!in_rdy_n && out_rdy_n, "R1", {in_rdy_n, out_rdy_n}, 1);

    // R3 ripple-down latency
    drive(1'b1, 8'hA5, 1'b0, a);
    e = cyc + 1;
    seen = -1;
    for (int i = 0; i < 100 && seen < 0; i++) begin
      drive(1'b0, '0, 1'b0, a);
      if (!out_rdy_n) seen = cyc;
    end
    check(seen == e + LAT_DN, "R3", seen - e, LAT_DN);
    check(dout == 8'hA5, "R3", dout, 8'hA5);
    drive(1'b0, '0, 1'b1, a);
    idle(3);
    check(out_rdy_n && exp_q.size() == 0, "R7", exp_q.size(), 0);

    // R8 reads on an empty chain do nothing
    for (int i = 0; i < 6; i++) drive(1'b0, '0, 1'b1, a);
    check(out_rdy_n, "R8", out_rdy_n, 1);
    drive(1'b1, 8'h3C, 1'b0, a);
    idle(LAT_DN + 3);
    check(!out_rdy_n && dout == 8'h3C, "R8", dout, 8'h3C);
    drive(1'b0, '0, 1'b1, a);
    idle(3);
    check(out_rdy_n && exp_q.size() == 0, "R8", exp_q.size(), 0);

    // R2 / R6 fill with no reads, keep offering past full
    acc_n = 0;
    for (int i = 0; i < 150; i++) begin
      drive(1'b1, W'(acc_n), 1'b0, a);
      if (a) acc_n++;
    end
    drive(1'b0, '0, 1'b0, a);
    check(acc_n == CAP, "R2", acc_n, CAP);
    check(in_rdy_n, "R2", in_rdy_n, 1);
    check(exp_q.size() == CAP, "R6", exp_q.size(), CAP);

    // R4 bubble-up latency
    idle(5);
    drive(1'b0, '0, 1'b1, a);
    e = cyc + 1;
    seen = -1;
    for (int i = 0; i < 100 && seen < 0; i++) begin
      drive(1'b0, '0, 1'b0, a);
      if (!in_rdy_n) seen = cyc;
    end
    check(seen == e + LAT_UP, "R4", seen - e, LAT_UP);

    // drain, order checked by monitor
    for (int i = 0; i < 120; i++) drive(1'b0, '0, 1'b1, a);
    check(exp_q.size() == 0 && out_rdy_n, "R7", exp_q.size(), 0);

    // R5 streaming
    idle(4);
    trk = 1; npop = 0;
    acc_n = 0;
    e = 0;
    for (int i = 0; i < 30; i++) begin
      drive(1'b1, W'(8'h40 + i), 1'b1, a);
      if (i == 0) e = cyc + 1;
      if (a) acc_n++;
    end
    for (int i = 0; i < 40; i++) drive(1'b0, '0, 1'b1, a);
    trk = 0;
    check(acc_n == 30, "R5", acc_n, 30);
    check(npop == 30, "R5", npop, 30);
    check(last_pop - first_pop == 29, "R5", last_pop - first_pop, 29);
    check(first_pop == e + LAT_DN + 1, "R3", first_pop - e, LAT_DN + 1);

    // R7 random enables
    for (int i = 0; i < 800; i++)
      drive(($urandom % 10) < 6, W'($urandom), ($urandom % 10) < 5, a);
    for (int i = 0; i < 150; i++) drive(1'b0, '0, 1'b1, a);
    check(exp_q.size() == 0 && out_rdy_n, "R7", exp_q.size(), 0);

    // R1 reset while holding data
    for (int i = 0; i < 10; i++) drive(1'b1, W'(i), 1'b0, a);
    idle(20);
    @(negedge clk); rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    exp_q.delete();
    check(in_rdy_n && out_rdy_n, "R1", {in_rdy_n, out_rdy_n}, 3);
    @(negedge clk); rst = 1'b0;
    idle(25);
    check(out_rdy_n && !in_rdy_n, "R1", {in_rdy_n, out_rdy_n}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule